// File: doc/BRIEF.md
# Grouped Data Bus Inversion Codec

This block sits between a 64-bit logical data word and a wide bus whose lines and flags are active low: a logical one is driven as a low voltage. To keep supply noise bounded, the word is cut into four 16-bit groups, and each group carries its own inversion flag. The transmit path counts the logical ones in each group. When a group holds more than half ones, it sends that group inverted and asserts the group's flag. As a result, no group ever pulls more than 8 of its 16 data lines low. The flags are not counted toward that limit.

The receive path takes the driven lines and the flags and undoes the inversion group by group, which restores the logical word. Each direction is a single registered stage with its own valid strobe. The registered outputs hold their last value while no valid word arrives. Bus protocol phases, strobe timing and electrical buffering are handled elsewhere.

Top module: `dbi_codec`

## Requirements
- R1: Group g (g = 0..3) is data bits [16g+15:16g]; flag bit g of both flag ports covers exactly that group and no other.
- R2: A transmitted group with 8 or fewer logical ones is driven as the bitwise complement of its logical value (active-low levels), and its flag line is driven high (1 = not inverted).
- R3: A transmitted group with 9 or more logical ones is driven equal to its logical value (inverted relative to R2), and its flag line is driven low (0 = inverted).
- R4: Whenever `tx_valid_o` is high, each 16-bit group of `tx_bus_o` has at most 8 bits at 0 (lines driven low).
- R5: The receive path gives `rx_data_o` group g = `rx_bus_i` group g when `rx_flag_n_i[g]` is 0, and the complement of `rx_bus_i` group g when it is 1.
- R6: Each direction has one clock cycle of latency: `tx_valid_o` and `rx_valid_o` equal their input valid from the previous cycle, and the data come with them.
- R7: While an input valid is low, the outputs of that direction keep their previous values.
- R8: In the cycle after reset is high, both valids are 0, `tx_bus_o` and `tx_flag_n_o` are all ones (no line low), and `rx_data_o` is all zeros.
- R9: Feeding the transmit outputs into the receive inputs returns the original logical word two cycles after it entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid_i | input | 1 | Logical word to encode is present |
| tx_data_i | input | 64 | Logical word to encode |
| tx_valid_o | output | 1 | Encoded word is present |
| tx_bus_o | output | 64 | Line levels to drive (0 = low voltage) |
| tx_flag_n_o | output | 4 | Per-group inversion flag levels (0 = inverted) |
| rx_valid_i | input | 1 | Received lines are present |
| rx_bus_i | input | 64 | Received line levels |
| rx_flag_n_i | input | 4 | Received per-group flag levels (0 = inverted) |
| rx_valid_o | output | 1 | Decoded word is present |
| rx_data_o | output | 64 | Restored logical word |

## Verification
A wrong inversion decision shows up at the ports one cycle after the word enters. Either a group of `tx_bus_o` drives more than 8 lines low, or its flag disagrees with the ones count of the word that came in. A swapped or miswired group shows up the same cycle as a flag that covers the wrong slice, and the round trip fails two cycles after entry. A stuck or leaking output register shows up on the first idle cycle, when the held value changes.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int DEF_GROUP_W = 16;
    localparam int DEF_GROUPS  = 4;

    typedef enum logic {
        LANE_PASS   = 1'b0,
        LANE_INVERT = 1'b1
    } lane_mode_e;

endpackage

// File: rtl/dbi_enc_lane.sv
module dbi_enc_lane
    import dbi_pkg::*;
#(
    parameter int W = DEF_GROUP_W
) (
    input  logic [W-1:0] data_i,
    output logic [W-1:0] line_o,
    output logic         flag_n_o
);
    localparam int CW    = $clog2(W + 1);
    localparam int LIMIT = W / 2;

    logic [CW-1:0] ones;
    lane_mode_e    mode;

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(data_i[i]);
        end
        mode = (ones > CW'(LIMIT)) ? LANE_INVERT : LANE_PASS;
        // active-low lines: uninverted means complement of logical value
        line_o   = (mode == LANE_INVERT) ? data_i : ~data_i;
        flag_n_o = (mode != LANE_INVERT);
    end
endmodule

// File: rtl/dbi_dec_lane.sv
module dbi_dec_lane
    import dbi_pkg::*;
#(
    parameter int W = DEF_GROUP_W
) (
    input  logic [W-1:0] line_i,
    input  logic         flag_n_i,
    output logic [W-1:0] data_o
);
    lane_mode_e mode;

    always_comb begin
        mode   = flag_n_i ? LANE_PASS : LANE_INVERT;
        data_o = (mode == LANE_INVERT) ? line_i : ~line_i;
    end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
    import dbi_pkg::*;
#(
    parameter int GROUP_W = DEF_GROUP_W,
    parameter int GROUPS  = DEF_GROUPS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         tx_valid_i,
    input  logic [GROUP_W*GROUPS-1:0]    tx_data_i,
    output logic                         tx_valid_o,
    output logic [GROUP_W*GROUPS-1:0]    tx_bus_o,
    output logic [GROUPS-1:0]            tx_flag_n_o,
    input  logic                         rx_valid_i,
    input  logic [GROUP_W*GROUPS-1:0]    rx_bus_i,
    input  logic [GROUPS-1:0]            rx_flag_n_i,
    output logic                         rx_valid_o,
    output logic [GROUP_W*GROUPS-1:0]    rx_data_o
);
    localparam int BUS_W = GROUP_W * GROUPS;

    logic [BUS_W-1:0]  enc_bus;
    logic [GROUPS-1:0] enc_flag_n;
    logic [BUS_W-1:0]  dec_data;

    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
        dbi_enc_lane #(.W(GROUP_W)) u_enc (
            .data_i   (tx_data_i[g*GROUP_W +: GROUP_W]),
            .line_o   (enc_bus[g*GROUP_W +: GROUP_W]),
            .flag_n_o (enc_flag_n[g])
        );
        dbi_dec_lane #(.W(GROUP_W)) u_dec (
            .line_i   (rx_bus_i[g*GROUP_W +: GROUP_W]),
            .flag_n_i (rx_flag_n_i[g]),
            .data_o   (dec_data[g*GROUP_W +: GROUP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid_o  <= 1'b0;
            tx_bus_o    <= '1;
            tx_flag_n_o <= '1;
        end else begin
            tx_valid_o <= tx_valid_i;
            if (tx_valid_i) begin
                tx_bus_o    <= enc_bus;
                tx_flag_n_o <= enc_flag_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            rx_valid_o <= rx_valid_i;
            if (rx_valid_i) begin
                rx_data_o <= dec_data;
            end
        end
    end
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk #(
    parameter int GROUP_W = 16,
    parameter int GROUPS  = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      tx_valid_i,
    input logic [GROUP_W*GROUPS-1:0] tx_data_i,
    input logic                      tx_valid_o,
    input logic [GROUP_W*GROUPS-1:0] tx_bus_o,
    input logic [GROUPS-1:0]         tx_flag_n_o,
    input logic                      rx_valid_i,
    input logic [GROUP_W*GROUPS-1:0] rx_bus_i,
    input logic [GROUPS-1:0]         rx_flag_n_i,
    input logic                      rx_valid_o,
    input logic [GROUP_W*GROUPS-1:0] rx_data_o
);
    localparam int HALF = GROUP_W / 2;

    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (!tx_valid_o && !rx_valid_o && (&tx_bus_o) && (&tx_flag_n_o) && (rx_data_o == '0)));

    assert_tx_latency_R6: assert property (@(posedge clk) disable iff (rst)
        tx_valid_i |=> tx_valid_o);
    assert_tx_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_valid_i |=> !tx_valid_o);
    assert_rx_latency_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid_i |=> rx_valid_o);
    assert_rx_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_i |=> !rx_valid_o);

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_valid_i |=> ($stable(tx_bus_o) && $stable(tx_flag_n_o)));
    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_i |=> $stable(rx_data_o));

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        assert_low_limit_R4: assert property (@(posedge clk) disable iff (rst)
            tx_valid_o |-> ($countones(~tx_bus_o[g*GROUP_W +: GROUP_W]) <= HALF));

        assert_flag_rule_R3: assert property (@(posedge clk) disable iff (rst)
            tx_valid_i |=> (tx_flag_n_o[g] ==
                ($countones($past(tx_data_i[g*GROUP_W +: GROUP_W])) <= HALF)));

        assert_decode_R5: assert property (@(posedge clk) disable iff (rst)
            rx_valid_i |=> (rx_data_o[g*GROUP_W +: GROUP_W] ==
                ($past(rx_flag_n_i[g]) ? ~$past(rx_bus_i[g*GROUP_W +: GROUP_W])
                                       :  $past(rx_bus_i[g*GROUP_W +: GROUP_W]))));
    end
endmodule

bind dbi_codec dbi_codec_chk #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_chk (.*);

// File: tb/dbi_codec_test.sv
module dbi_codec_test;
    localparam int CLK_PERIOD = 10;
    localparam int GW = 16;
    localparam int NG = 4;
    localparam int BW = GW * NG;

    typedef struct packed {
        logic [BW-1:0] bus;
        logic [NG-1:0] flag_n;
    } tx_exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_valid_i = 1'b0;
    logic [BW-1:0] tx_data_i = '0;
    logic          tx_valid_o;
    logic [BW-1:0] tx_bus_o;
    logic [NG-1:0] tx_flag_n_o;
    logic          rx_valid_drv = 1'b0;
    logic [BW-1:0] rx_bus_drv = '0;
    logic [NG-1:0] rx_flag_drv = '1;
    logic          loop = 1'b0;
    logic          rx_valid_i;
    logic [BW-1:0] rx_bus_i;
    logic [NG-1:0] rx_flag_n_i;
    logic          rx_valid_o;
    logic [BW-1:0] rx_data_o;

    assign rx_valid_i  = loop ? tx_valid_o  : rx_valid_drv;
    assign rx_bus_i    = loop ? tx_bus_o    : rx_bus_drv;
    assign rx_flag_n_i = loop ? tx_flag_n_o : rx_flag_drv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbi_codec uut (
        .clk(clk), .rst(rst),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
        .tx_valid_o(tx_valid_o), .tx_bus_o(tx_bus_o), .tx_flag_n_o(tx_flag_n_o),
        .rx_valid_i(rx_valid_i), .rx_bus_i(rx_bus_i), .rx_flag_n_i(rx_flag_n_i),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    tx_exp_t       tx_q[$];
    logic [BW-1:0] rx_q[$];
    tx_exp_t       tx_last;
    logic [BW-1:0] rx_last;
    bit            tx_seen = 1'b0;
    bit            rx_seen = 1'b0;

    function automatic tx_exp_t model_enc(logic [BW-1:0] d);
        tx_exp_t e;
        for (int g = 0; g < NG; g++) begin
            logic [GW-1:0] s;
            s = d[g*GW +: GW];
            if ($countones(s) > GW / 2) begin
                e.bus[g*GW +: GW] = s;
                e.flag_n[g] = 1'b0;
            end else begin
                e.bus[g*GW +: GW] = ~s;
                e.flag_n[g] = 1'b1;
            end
        end
        return e;
    endfunction

    task automatic check(string req, logic [BW+NG-1:0] act, logic [BW+NG-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares registered outputs between edges
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (tx_valid_o) begin
                if (tx_q.size() == 0) begin
                    check("R6 unexpected tx_valid_o", 1, 0);
                end else begin
                    tx_exp_t e;
                    e = tx_q.pop_front();
                    check("R1/R2/R3 encode", {tx_bus_o, tx_flag_n_o}, {e.bus, e.flag_n});
                    tx_last = e;
                    tx_seen = 1'b1;
                end
                for (int g = 0; g < NG; g++) begin
                    check("R4 low lines per group",
                          ($countones(~tx_bus_o[g*GW +: GW]) <= GW / 2), 1);
                end
            end else if (tx_seen) begin
                check("R7 tx hold", {tx_bus_o, tx_flag_n_o}, {tx_last.bus, tx_last.flag_n});
            end
            if (rx_valid_o) begin
                if (rx_q.size() == 0) begin
                    check("R6 unexpected rx_valid_o", 1, 0);
                end else begin
                    logic [BW-1:0] x;
                    x = rx_q.pop_front();
                    check("R5/R9 decode", rx_data_o, x);
                    rx_last = x;
                    rx_seen = 1'b1;
                end
            end else if (rx_seen) begin
                check("R7 rx hold", rx_data_o, rx_last);
            end
        end
    end

    // driver tasks: called at a negedge, leave at the next negedge
    task automatic send_tx(logic [BW-1:0] d);
        tx_valid_i = 1'b1;
        tx_data_i  = d;
        tx_q.push_back(model_enc(d));
        if (loop) rx_q.push_back(d);
        @(negedge clk);
    endtask

    task automatic send_rx(logic [BW-1:0] b, logic [NG-1:0] f);
        logic [BW-1:0] x;
        rx_valid_drv = 1'b1;
        rx_bus_drv   = b;
        rx_flag_drv  = f;
        for (int g = 0; g < NG; g++)
            x[g*GW +: GW] = f[g] ? ~b[g*GW +: GW] : b[g*GW +: GW];
        rx_q.push_back(x);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        tx_valid_i   = 1'b0;
        tx_data_i    = {BW{1'b1}};
        rx_valid_drv = 1'b0;
        rx_bus_drv   = '0;
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state, sampled after the reset cycles
        check("R8 reset tx", {tx_valid_o, tx_bus_o, tx_flag_n_o}, {1'b0, {BW{1'b1}}, {NG{1'b1}}});
        check("R8 reset rx", {rx_valid_o, rx_data_o}, '0);

        // R2/R3 boundaries: 8 ones passes, 9 ones inverts, per-group mix (R1)
        send_tx(64'h0000_0000_0000_0000);
        send_tx(64'hFFFF_FFFF_FFFF_FFFF);
        send_tx(64'h00FF_00FF_00FF_00FF);
        send_tx(64'h01FF_01FF_01FF_01FF);
        send_tx(64'h007F_FFFF_0000_01FF);
        send_tx(64'h01FF_00FF_FFFF_8000);
        idle(3);

        // R5 direct decode with each flag pattern
        for (int f = 0; f < 16; f++) begin
            send_rx({$urandom, $urandom}, f[NG-1:0]);
        end
        idle(3);

        // R9 round trip via loopback, boundary and random words
        loop = 1'b1;
        idle(1);
        send_tx(64'h5555_AAAA_FF00_00FF);
        send_tx(64'hFE00_7FFF_0001_FFFE);
        for (int i = 0; i < 200; i++) begin
            send_tx({$urandom, $urandom});
            if (i % 37 == 0) idle(2);
        end
        idle(4);
        loop = 1'b0;
        idle(2);

        // R6 queues must be drained: no word lost or added
        check("R6 tx queue drained", tx_q.size(), 0);
        check("R6 rx queue drained", rx_q.size(), 0);

        // R8 reset mid-run clears outputs again
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset again", {tx_valid_o, tx_bus_o, tx_flag_n_o, rx_valid_o, rx_data_o},
              {1'b0, {BW{1'b1}}, {NG{1'b1}}, 1'b0, {BW{1'b0}}});
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule